// File: doc/BRIEF.md
# Thread Interrupt Presentation Context

This block holds the interrupt presentation state of a single processor thread behind a small byte-addressed register window. The window has three rings, one for the guest OS, one for the hypervisor pool and one for the hypervisor. Each ring tracks which priorities are pending in a bit set, keeps the thread's current priority, and derives the most favoured pending priority. The routing logic posts events through a notification port that carries a ring number and a priority. The block raises an exception request to the thread when a pending priority beats the current one.

The thread services the request with a 16-bit acknowledge read. The read reports the kind of exception and takes the winning priority as the new current priority. It retires that pending bit in the same edge. Software later writes the current priority back to reopen the thread. The pool ring also has a context word, made of a valid flag and a tag. A special pull read returns that word and drops the valid flag, and the pool ring presents nothing while the flag is clear.

Top module: `thrd_irq_ctx`

## Requirements
- R1: After reset every ring's current priority is 0x00 and its pending set is empty, the pool context word is zero, exc_req is low and bus_rdata is zero.
- R2: A notification with ring code 0 (OS), 1 (pool) or 2 (hypervisor) and priority p sets bit p of that ring's pending byte (ring byte offset 2). Ring code 3 changes nothing. The best-priority byte (offset 7) is the index of the lowest set pending bit, or 0xFF when the set is empty.
- R3: exc_req is high exactly when the hypervisor ring's best priority is numerically below its current priority, or when the pool context is valid and the same holds for the pool ring. The OS ring never raises it. The status byte (offset 0) reads 0x80 while the hypervisor ring fires, 0x40 while the pool ring fires, and 0x00 otherwise.
- R4: A byte write to ring offset 1 sets that ring's current priority. Writing 0xFF admits every priority.
- R5: A half-word read at 0x800 while the hypervisor ring fires returns bits 15:14 = 2 and bits 7:0 = that ring's best priority. In the same edge the current priority takes that value and the pending bit is cleared.
- R6: When the hypervisor ring does not fire but the pool ring does, the acknowledge returns bits 15:14 = 1 and the pool ring's best priority, and updates the pool ring the same way. The hypervisor ring takes precedence even when the pool priority is more favoured.
- R7: When neither ring fires, the acknowledge returns bits 15:14 = 0 with the hypervisor current priority in bits 7:0, and it changes no state.
- R8: A notification in the same cycle as an acknowledge is never lost: a notification at the priority being taken stays pending. The acknowledge returns the best priority as it stood before that notification.
- R9: The pool context word is a 32-bit register at 0x028, with bit 31 as the valid flag and bits 23:0 as the tag. A 32-bit read at 0x828 returns the word and clears bit 31.
- R10: Read data appears on bus_rdata the cycle after the request and holds until the next read. Reads of unmapped addresses return 0. Writes to any ring byte other than offset 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ntf_vld | input | 1 | Notification strobe from routing logic |
| ntf_ring | input | 2 | Target ring: 0 OS, 1 pool, 2 hypervisor, 3 none |
| ntf_prio | input | 3 | Notified priority, 0 most favoured |
| bus_req | input | 1 | MMIO request strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data, bytes in bits 7:0 |
| bus_rdata | output | 32 | Registered read data |
| exc_req | output | 1 | Exception request to the thread |

## Verification
Several notifications arrive at different priorities, and the acknowledges must come back in the order of the most favoured pending priority. That order separates lowest-index selection from arrival order. Pending priorities are set equal to, above and below the current priority, which shows whether the masking compare is strict. Acknowledges are issued in the same cycle as a notification, at the taken priority and at a better one, to confirm the pending bit survives and the returned value predates the new event. The pool tests set a more favoured pool event against a hypervisor event to check precedence, then pull the context to show pool presentation stops.

// File: rtl/thrd_ctx_pkg.sv
package thrd_ctx_pkg;

    localparam int NPRIO      = 8;
    localparam int PRIO_IDX_W = $clog2(NPRIO);
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int TAG_W      = 24;
    localparam int NRING      = 3;
    localparam int RING_IDX_W = 2;

    localparam int RING_OS   = 0;
    localparam int RING_POOL = 1;
    localparam int RING_HV   = 2;

    localparam logic [ADDR_W-1:0] ACK_ADDR     = 12'h800;
    localparam logic [ADDR_W-1:0] PULL_ADDR    = 12'h828;
    localparam logic [ADDR_W-1:0] POOL_W2_ADDR = 12'h028;

    localparam logic [2:0] OFS_STATUS = 3'd0;
    localparam logic [2:0] OFS_CUR    = 3'd1;
    localparam logic [2:0] OFS_PEND   = 3'd2;
    localparam logic [2:0] OFS_BEST   = 3'd7;

    localparam logic [7:0] PRIO_NONE = 8'hFF;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_POOL = 2'd1,
        EXC_PHYS = 2'd2,
        EXC_LSI  = 2'd3
    } exc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        exc_kind_e  kind;
        logic [5:0] zero;
        logic [7:0] prio;
    } ack_resp_t;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } pool_ctx_t;

    function automatic logic [7:0] best_of(input logic [NPRIO-1:0] pend);
        logic [7:0] res;
        res = PRIO_NONE;
        for (int i = NPRIO - 1; i >= 0; i--) begin
            if (pend[i]) res = 8'(i);
        end
        return res;
    endfunction

    function automatic logic [NPRIO-1:0] prio_mask(input logic [PRIO_IDX_W-1:0] p);
        return NPRIO'(1) << p;
    endfunction

endpackage

// File: rtl/prio_ring.sv
module prio_ring
    import thrd_ctx_pkg::*;
#(
    parameter exc_kind_e KIND = EXC_PHYS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ntf_set,
    input  logic [PRIO_IDX_W-1:0] ntf_prio,
    input  logic                  cur_we,
    input  logic [7:0]            cur_wdata,
    input  logic                  take,
    input  logic                  enable,
    output logic [7:0]            cur_q,
    output logic [NPRIO-1:0]      pend_q,
    output logic [7:0]            best,
    output logic                  fire,
    output logic [7:0]            status
);

    logic [NPRIO-1:0] take_mask;
    logic [NPRIO-1:0] set_mask;
    logic [NPRIO-1:0] pend_d;

    assign best      = best_of(pend_q);
    assign take_mask = (take && best != PRIO_NONE) ? prio_mask(best[PRIO_IDX_W-1:0]) : '0;
    assign set_mask  = ntf_set ? prio_mask(ntf_prio) : '0;
    assign pend_d    = (pend_q & ~take_mask) | set_mask;
    assign fire      = enable && (best < cur_q);
    assign status    = fire ? {KIND, 6'b0} : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cur_q  <= 8'h00;
        end else begin
            pend_q <= pend_d;
            if (take) cur_q <= best;
            else if (cur_we) cur_q <= cur_wdata;
        end
    end

    // R2 R8
    ntf_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        ntf_set |=> pend_q[$past(ntf_prio)]);

    // R5
    take_cur_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> cur_q == $past(best));

    // R3
    take_only_fire_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> fire);

endmodule

// File: rtl/pool_ctx.sv
module pool_ctx
    import thrd_ctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pull,
    output logic [DATA_W-1:0] word,
    output logic              vld
);

    pool_ctx_t ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (we) begin
            ctx_q.vld <= wdata[DATA_W-1];
            ctx_q.tag <= wdata[TAG_W-1:0];
        end else if (pull) begin
            ctx_q.vld <= 1'b0;
        end
    end

    assign vld  = ctx_q.vld;
    assign word = {ctx_q.vld, {(DATA_W-1-TAG_W){1'b0}}, ctx_q.tag};

    // R9
    pull_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (pull && !we) |=> !vld);

endmodule

// File: rtl/ack_sel.sv
module ack_sel
    import thrd_ctx_pkg::*;
(
    input  logic       hv_fire,
    input  logic       pool_fire,
    input  logic [7:0] hv_best,
    input  logic [7:0] pool_best,
    input  logic [7:0] hv_cur,
    output logic       take_hv,
    output logic       take_pool,
    output ack_resp_t  resp
);

    always_comb begin
        take_hv   = 1'b0;
        take_pool = 1'b0;
        resp.zero = '0;
        if (hv_fire) begin
            take_hv   = 1'b1;
            resp.kind = EXC_PHYS;
            resp.prio = hv_best;
        end else if (pool_fire) begin
            take_pool = 1'b1;
            resp.kind = EXC_POOL;
            resp.prio = pool_best;
        end else begin
            resp.kind = EXC_NONE;
            resp.prio = hv_cur;
        end
    end

    // R6
    always_comb begin
        one_take_chk: assert ($onehot0({take_hv, take_pool}));
    end

endmodule

// File: rtl/thrd_irq_ctx.sv
module thrd_irq_ctx
    import thrd_ctx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ntf_vld,
    input  logic [RING_IDX_W-1:0] ntf_ring,
    input  logic [PRIO_IDX_W-1:0] ntf_prio,
    input  logic                  bus_req,
    input  logic                  bus_wr,
    input  logic [1:0]            bus_size,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  exc_req
);

    logic [7:0]       cur_a    [NRING];
    logic [NPRIO-1:0] pend_a   [NRING];
    logic [7:0]       best_a   [NRING];
    logic [7:0]       status_a [NRING];
    logic [NRING-1:0] fire_a;
    logic [NRING-1:0] take_a;
    logic [NRING-1:0] cur_we_a;
    logic [NRING-1:0] en_a;

    acc_size_e             size;
    logic                  rd_req;
    logic                  wr_req;
    logic                  byte_hit;
    logic [RING_IDX_W-1:0] ring_sel;
    logic [2:0]            ofs;
    logic                  ack_hit;
    logic                  pull_hit;
    logic                  w2_hit;
    logic                  pool_vld;
    logic [DATA_W-1:0]     pool_word;
    logic                  take_hv;
    logic                  take_pool;
    ack_resp_t             ack_resp;
    logic [DATA_W-1:0]     rd_d;
    logic [DATA_W-1:0]     rdata_q;

    assign size     = acc_size_e'(bus_size);
    assign rd_req   = bus_req && !bus_wr;
    assign wr_req   = bus_req && bus_wr;
    assign byte_hit = (size == SZ_BYTE) && (bus_addr[ADDR_W-1:6] == '0)
                      && (bus_addr[5:4] != 2'd0) && !bus_addr[3];
    assign ring_sel = bus_addr[5:4] - 2'd1;
    assign ofs      = bus_addr[2:0];
    assign ack_hit  = rd_req && (size == SZ_HALF) && (bus_addr == ACK_ADDR);
    assign pull_hit = rd_req && (size == SZ_WORD) && (bus_addr == PULL_ADDR);
    assign w2_hit   = (size == SZ_WORD) && (bus_addr == POOL_W2_ADDR);

    generate
        for (genvar r = 0; r < NRING; r++) begin : g_ring
            localparam exc_kind_e RK = (r == RING_HV)   ? EXC_PHYS :
                                       (r == RING_POOL) ? EXC_POOL : EXC_NONE;
            if (r == RING_POOL) begin : g_en_pool
                assign en_a[r] = pool_vld;
            end else if (r == RING_HV) begin : g_en_hv
                assign en_a[r] = 1'b1;
            end else begin : g_en_os
                assign en_a[r] = 1'b0;
            end
            assign cur_we_a[r] = wr_req && byte_hit && (ring_sel == RING_IDX_W'(r))
                                 && (ofs == OFS_CUR);
            prio_ring #(.KIND(RK)) u_ring (
                .clk       (clk),
                .rst       (rst),
                .ntf_set   (ntf_vld && (ntf_ring == RING_IDX_W'(r))),
                .ntf_prio  (ntf_prio),
                .cur_we    (cur_we_a[r]),
                .cur_wdata (bus_wdata[7:0]),
                .take      (take_a[r]),
                .enable    (en_a[r]),
                .cur_q     (cur_a[r]),
                .pend_q    (pend_a[r]),
                .best      (best_a[r]),
                .fire      (fire_a[r]),
                .status    (status_a[r])
            );
        end
    endgenerate

    ack_sel u_ack (
        .hv_fire   (fire_a[RING_HV]),
        .pool_fire (fire_a[RING_POOL]),
        .hv_best   (best_a[RING_HV]),
        .pool_best (best_a[RING_POOL]),
        .hv_cur    (cur_a[RING_HV]),
        .take_hv   (take_hv),
        .take_pool (take_pool),
        .resp      (ack_resp)
    );

    assign take_a[RING_OS]   = 1'b0;
    assign take_a[RING_POOL] = ack_hit && take_pool;
    assign take_a[RING_HV]   = ack_hit && take_hv;

    pool_ctx u_pool (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_req && w2_hit),
        .wdata (bus_wdata),
        .pull  (pull_hit),
        .word  (pool_word),
        .vld   (pool_vld)
    );

    always_comb begin
        rd_d = '0;
        if (ack_hit) begin
            rd_d = DATA_W'(ack_resp);
        end else if (pull_hit || (rd_req && w2_hit)) begin
            rd_d = pool_word;
        end else if (rd_req && byte_hit && ring_sel < RING_IDX_W'(NRING)) begin
            case (ofs)
                OFS_STATUS: rd_d = DATA_W'(status_a[ring_sel]);
                OFS_CUR:    rd_d = DATA_W'(cur_a[ring_sel]);
                OFS_PEND:   rd_d = DATA_W'(8'(pend_a[ring_sel]));
                OFS_BEST:   rd_d = DATA_W'(best_a[ring_sel]);
                default:    rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_d;
    end

    assign bus_rdata = rdata_q;
    assign exc_req   = fire_a[RING_HV] | fire_a[RING_POOL];

    // R3
    pool_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req && !fire_a[RING_HV]) |-> pool_vld);

    // R5
    ack_phys_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && fire_a[RING_HV]) |=> (bus_rdata[15:14] == 2'd2)
                                         && (bus_rdata[7:0] == cur_a[RING_HV]));

    // R7
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !exc_req) |=> $stable(cur_a[RING_HV]) && (bus_rdata[15:14] == 2'd0));

endmodule

// File: tb/thrd_irq_ctx_bench.sv
module thrd_irq_ctx_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        ntf_vld;
    logic [1:0]  ntf_ring;
    logic [2:0]  ntf_prio;
    logic        bus_req;
    logic        bus_wr;
    logic [1:0]  bus_size;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        exc_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    thrd_irq_ctx u_thrd_irq_ctx (
        .clk(clk), .rst(rst), .ntf_vld(ntf_vld), .ntf_ring(ntf_ring),
        .ntf_prio(ntf_prio), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .exc_req(exc_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ntf_vld = 0; ntf_ring = 0; ntf_prio = 0;
        bus_req = 0; bus_wr = 0; bus_size = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic bus_op(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
        rd = bus_rdata;
    endtask

    task automatic wr8(input logic [11:0] a, input logic [7:0] d);
        logic [31:0] unused;
        bus_op(1'b1, 2'd0, a, {24'h0, d}, unused);
    endtask

    task automatic rd8(input logic [11:0] a, output logic [31:0] rd);
        bus_op(1'b0, 2'd0, a, 32'h0, rd);
    endtask

    task automatic ack(output logic [31:0] rd);
        bus_op(1'b0, 2'd1, 12'h800, 32'h0, rd);
    endtask

    task automatic notify(input logic [1:0] ring, input logic [2:0] p);
        @(negedge clk);
        ntf_vld = 1; ntf_ring = ring; ntf_prio = p;
        @(negedge clk);
        ntf_vld = 0;
    endtask

    task automatic ack_with_notify(input logic [1:0] ring, input logic [2:0] p,
                                   output logic [31:0] rd);
        @(negedge clk);
        ntf_vld = 1; ntf_ring = ring; ntf_prio = p;
        bus_req = 1; bus_wr = 0; bus_size = 2'd1; bus_addr = 12'h800;
        @(negedge clk);
        ntf_vld = 0; bus_req = 0;
        rd = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        chk("R1 exc_req", {31'h0, exc_req}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        rd8(12'h031, v); chk("R1 hv cur", v, 32'h00);
        rd8(12'h011, v); chk("R1 os cur", v, 32'h00);
        rd8(12'h032, v); chk("R1 hv pend", v, 32'h00);
        rd8(12'h037, v); chk("R2 empty best", v, 32'hFF);
        bus_op(1'b0, 2'd2, 12'h028, 32'h0, v); chk("R1 pool word", v, 32'h0);
        bus_op(1'b0, 2'd2, 12'h400, 32'h0, v); chk("R10 unmapped", v, 32'h0);
        chk("R10 hold", bus_rdata, 32'h0);
    endtask

    task automatic t_order();
        logic [31:0] v;
        do_reset();
        wr8(12'h031, 8'hFF);
        rd8(12'h031, v); chk("R4 cur write", v, 32'hFF);
        notify(2'd2, 3'd5); notify(2'd2, 3'd2); notify(2'd2, 3'd6);
        rd8(12'h032, v); chk("R2 pend set", v, 32'h64);
        rd8(12'h037, v); chk("R2 best", v, 32'h02);
        chk("R3 exc high", {31'h0, exc_req}, 32'h1);
        rd8(12'h030, v); chk("R3 status phys", v, 32'h80);
        ack(v); chk("R5 ack first", v, 32'h8002);
        rd8(12'h031, v); chk("R5 cur taken", v, 32'h02);
        rd8(12'h032, v); chk("R5 bit cleared", v, 32'h60);
        chk("R3 exc low after ack", {31'h0, exc_req}, 32'h0);
        wr8(12'h031, 8'hFF);
        chk("R4 reopen", {31'h0, exc_req}, 32'h1);
        ack(v); chk("R5 ack second", v, 32'h8005);
        wr8(12'h031, 8'hFF);
        ack(v); chk("R5 ack third", v, 32'h8006);
        ack(v); chk("R7 idle ack", v, 32'h0006);
        rd8(12'h031, v); chk("R7 cur unchanged", v, 32'h06);
        wr8(12'h031, 8'hFF);
        ack(v); chk("R7 idle open", v, 32'h00FF);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        do_reset();
        wr8(12'h031, 8'h03);
        notify(2'd2, 3'd4);
        chk("R3 masked lower", {31'h0, exc_req}, 32'h0);
        notify(2'd2, 3'd3);
        chk("R3 masked equal", {31'h0, exc_req}, 32'h0);
        rd8(12'h030, v); chk("R3 status idle", v, 32'h00);
        notify(2'd2, 3'd1);
        chk("R3 fires better", {31'h0, exc_req}, 32'h1);
        ack(v); chk("R5 masked ack", v, 32'h8001);
        rd8(12'h032, v); chk("R5 left pending", v, 32'h18);
        chk("R3 exc after ack", {31'h0, exc_req}, 32'h0);
    endtask

    task automatic t_atomic();
        logic [31:0] v;
        do_reset();
        wr8(12'h031, 8'hFF);
        notify(2'd2, 3'd4);
        ack_with_notify(2'd2, 3'd4, v); chk("R8 same prio resp", v, 32'h8004);
        rd8(12'h032, v); chk("R8 same prio kept", v, 32'h10);
        rd8(12'h031, v); chk("R8 cur", v, 32'h04);
        do_reset();
        wr8(12'h031, 8'hFF);
        notify(2'd2, 3'd3);
        ack_with_notify(2'd2, 3'd1, v); chk("R8 prior best", v, 32'h8003);
        rd8(12'h032, v); chk("R8 better kept", v, 32'h02);
        chk("R8 exc again", {31'h0, exc_req}, 32'h1);
    endtask

    task automatic t_rings();
        logic [31:0] v;
        do_reset();
        wr8(12'h031, 8'hFF);
        notify(2'd3, 3'd0);
        rd8(12'h012, v); chk("R2 ring3 os", v, 32'h00);
        rd8(12'h022, v); chk("R2 ring3 pool", v, 32'h00);
        rd8(12'h032, v); chk("R2 ring3 hv", v, 32'h00);
        wr8(12'h011, 8'hFF);
        notify(2'd0, 3'd0);
        rd8(12'h012, v); chk("R2 os pend", v, 32'h01);
        chk("R3 os silent", {31'h0, exc_req}, 32'h0);
        wr8(12'h012, 8'hAA);
        rd8(12'h012, v); chk("R10 pend write ignored", v, 32'h01);
        wr8(12'h017, 8'h00);
        rd8(12'h017, v); chk("R10 best write ignored", v, 32'h00);
    endtask

    task automatic t_pool();
        logic [31:0] v;
        do_reset();
        wr8(12'h021, 8'hFF);
        notify(2'd1, 3'd2);
        chk("R3 pool invalid silent", {31'h0, exc_req}, 32'h0);
        bus_op(1'b1, 2'd2, 12'h028, 32'h800000AB, v);
        bus_op(1'b0, 2'd2, 12'h028, 32'h0, v); chk("R9 word read", v, 32'h800000AB);
        chk("R3 pool fires", {31'h0, exc_req}, 32'h1);
        rd8(12'h020, v); chk("R3 status pool", v, 32'h40);
        ack(v); chk("R6 pool ack", v, 32'h4002);
        rd8(12'h021, v); chk("R6 pool cur", v, 32'h02);
        wr8(12'h031, 8'hFF);
        notify(2'd2, 3'd6);
        notify(2'd1, 3'd1);
        ack(v); chk("R6 hv precedence", v, 32'h8006);
        chk("R6 pool still fires", {31'h0, exc_req}, 32'h1);
        bus_op(1'b0, 2'd2, 12'h828, 32'h0, v); chk("R9 pull value", v, 32'h800000AB);
        bus_op(1'b0, 2'd2, 12'h028, 32'h0, v); chk("R9 valid cleared", v, 32'h000000AB);
        chk("R9 pool silent", {31'h0, exc_req}, 32'h0);
        rd8(12'h022, v); chk("R9 pool pend kept", v, 32'h02);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1;
        idle_inputs();
        t_reset();
        t_order();
        t_mask();
        t_atomic();
        t_rings();
        t_pool();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule